// File: doc/BRIEF.md
# APB General-Purpose I/O Controller with Interrupts

This block gives software control of a bank of general-purpose pins through an APB slave. Each pin can be an input or an output. Output levels change only through two write-only strobe registers, one that raises and one that lowers the selected pins. The block samples the pins through a two-flop synchroniser. Each pin can also be routed through a debounce filter clocked by a programmable slow tick. Software reads the filtered pin levels back from an input register.

Every pin can raise an interrupt. Three per-pin configuration planes select the trigger:
- level or edge,
- one edge or both edges,
- polarity: rising or high against falling or low.

An enable plane decides whether a pin may latch a raw status bit. A mask plane, in which a 1 blocks the pin, filters the latched bits into a masked status. All masked bits are ORed into one interrupt line. A write-one-to-clear register removes latched bits. A level that is still active latches again at once.

Top module: `pio_apb_ctrl`

## Requirements
- R1: After reset every register reads 0, `gpio_oe` and `gpio_out` are all 0 and `irq` is 0.
- R2: The direction word at byte offset 0x00 reads back as written, and bit n drives `gpio_oe[n]`, where 1 means output and 0 means input.
- R3: A write to offset 0x08 sets every output bit written as 1, and a write to offset 0x0C clears every output bit written as 1. Bits written as 0 keep their value. The output word reads back at 0x10 and drives `gpio_out`. Writes to 0x10 are ignored, and 0x08 and 0x0C read as 0.
- R4: Offset 0x14 returns the pin levels after the two-flop synchroniser, or after the debounce filter where that is enabled.
- R5: With the sense bit (0x1C) at 0 and the both-edge bit (0x20) at 0, a polarity bit (0x24) of 1 latches raw status on a rising edge and 0 latches it on a falling edge. A pin change reaches `irq` on the third rising clock edge after the change.
- R6: With the sense bit at 0 and the both-edge bit at 1, either edge latches raw status, whatever the polarity bit holds.
- R7: With the sense bit at 1, a polarity of 1 latches on a high level and 0 on a low level. A level that is still active latches again straight after it is cleared.
- R8: Raw status (0x28) latches only for pins whose enable bit (0x18) is 1.
- R9: Writing 1 to a bit at 0x34 clears that latched raw bit. A trigger in the same cycle wins over the clear.
- R10: A mask bit (0x2C) of 1 hides the pin. Masked status (0x30) is raw AND NOT mask, and `irq` is the OR of the masked status bits.
- R11: A per-pin enable at 0x38 selects the debounce filter. The low 16 bits of 0x3C set the tick period to value+1 clocks. A filtered pin takes a new level only after the input has differed from it on 4 consecutive ticks.
- R12: Offset 0x04 and unmapped offsets read as 0. `pready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| gpio_in | input | 32 | Pin input levels |
| gpio_out | output | 32 | Pin output levels |
| gpio_oe | output | 32 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- the set and clear strobes reach `gpio_out` on the next cycle;
- a clear with no trigger in the same cycle removes the latched bit;
- a raw bit can rise only if its enable was set;
- a fully masked bank never raises `irq`;
- a debounced pin never changes level except just after a tick.

Only the bench scenarios can show the rest:
- the trigger outcome of each of the five modes over a series of level transitions;
- the re-latch of an active level after a clear;
- the exact three-edge latency to `irq`;
- rejection of a short glitch by the filter.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // Register byte offsets: software decodes these
  localparam logic [7:0] OFS_DIR   = 8'h00;
  localparam logic [7:0] OFS_CTRL  = 8'h04;
  localparam logic [7:0] OFS_SET   = 8'h08;
  localparam logic [7:0] OFS_CLR   = 8'h0C;
  localparam logic [7:0] OFS_OUT   = 8'h10;
  localparam logic [7:0] OFS_IN    = 8'h14;
  localparam logic [7:0] OFS_IEN   = 8'h18;
  localparam logic [7:0] OFS_SENSE = 8'h1C;
  localparam logic [7:0] OFS_BOTH  = 8'h20;
  localparam logic [7:0] OFS_POL   = 8'h24;
  localparam logic [7:0] OFS_RAW   = 8'h28;
  localparam logic [7:0] OFS_MASK  = 8'h2C;
  localparam logic [7:0] OFS_MSTAT = 8'h30;
  localparam logic [7:0] OFS_ICLR  = 8'h34;
  localparam logic [7:0] OFS_DBEN  = 8'h38;
  localparam logic [7:0] OFS_DBDIV = 8'h3C;

  // Per-pin trigger evaluation over a 32-bit plane
  function automatic logic [31:0] pio_hit(input logic [31:0] cur, input logic [31:0] prev,
                                          input logic [31:0] en, input logic [31:0] sense,
                                          input logic [31:0] both, input logic [31:0] pol);
    logic [31:0] rise, fall, edg, lvl;
    rise = cur & ~prev;
    fall = ~cur & prev;
    edg  = (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
    lvl  = (pol & cur) | (~pol & ~cur);
    return en & ((sense & lvl) | (~sense & edg));
  endfunction

  // A trigger wins over a clear in the same cycle
  function automatic logic [31:0] pio_raw_next(input logic [31:0] raw, input logic [31:0] hit,
                                               input logic [31:0] clr);
    return (raw & ~clr) | hit;
  endfunction

  function automatic logic [31:0] pio_masked(input logic [31:0] raw, input logic [31:0] mask);
    return raw & ~mask;
  endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pio_debounce.sv
module pio_debounce #(
  parameter int unsigned NPINS    = 32,
  parameter int unsigned DB_TICKS = 4,
  parameter int unsigned DIV_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] din,
  input  logic [NPINS-1:0] db_en,
  input  logic [DIV_W-1:0] div,
  output logic [NPINS-1:0] dout,
  output logic             tick
);
  localparam int unsigned CW = $clog2(DB_TICKS) + 1;

  logic [DIV_W-1:0] tcnt;
  assign tick = (tcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tcnt <= '0;
    else if (tick) tcnt <= '0;
    else           tcnt <= tcnt + 1'b1;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic          st;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= 1'b0;
        cnt <= '0;
      end else if (!db_en[i]) begin
        st  <= din[i];          // track so enabling causes no glitch
        cnt <= '0;
      end else if (tick) begin
        if (din[i] != st) begin
          if (cnt == CW'(DB_TICKS - 1)) begin
            st  <= din[i];
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
    assign dout[i] = db_en[i] ? st : din[i];
  end
endmodule

// File: rtl/pio_irq_detect.sv
module pio_irq_detect
  import pio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_v,
  input  logic [NPINS-1:0] en,
  input  logic [NPINS-1:0] sense,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] clr,
  input  logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] hit,
  output logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] masked,
  output logic             irq
);
  logic [NPINS-1:0] prev;
  logic [31:0]      hit_w, nxt_w, msk_w;

  assign hit_w  = pio_hit(32'(pin_v), 32'(prev), 32'(en), 32'(sense), 32'(both), 32'(pol));
  assign hit    = hit_w[NPINS-1:0];
  assign nxt_w  = pio_raw_next(32'(raw), 32'(hit), 32'(clr));
  assign msk_w  = pio_masked(32'(raw), 32'(mask));
  assign masked = msk_w[NPINS-1:0];
  assign irq    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      raw  <= '0;
    end else begin
      prev <= pin_v;
      raw  <= nxt_w[NPINS-1:0];
    end
  end
endmodule

// File: rtl/pio_apb_ctrl.sv
module pio_apb_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned NPINS    = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DB_TICKS = 4,
  parameter int unsigned DIV_W    = 16
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic [NPINS-1:0]  gpio_in,
  output logic [NPINS-1:0]  gpio_out,
  output logic [NPINS-1:0]  gpio_oe,
  output logic              irq
);
  logic [NPINS-1:0] dir_q, out_q, ien_q, sense_q, both_q, pol_q, mask_q, db_en_q;
  logic [DIV_W-1:0] div_q;
  logic [NPINS-1:0] pin_s, pin_v, hit, raw_q, masked;
  logic             tick;

  // Named write events
  logic             wr;
  logic [NPINS-1:0] set_pulse, clr_pulse, icl_pulse;

  assign wr        = psel & penable & pwrite;
  assign set_pulse = (wr && paddr == ADDR_W'(OFS_SET))  ? pwdata[NPINS-1:0] : '0;
  assign clr_pulse = (wr && paddr == ADDR_W'(OFS_CLR))  ? pwdata[NPINS-1:0] : '0;
  assign icl_pulse = (wr && paddr == ADDR_W'(OFS_ICLR)) ? pwdata[NPINS-1:0] : '0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      db_en_q <= '0;
      div_q   <= '0;
    end else begin
      out_q <= (out_q | set_pulse) & ~clr_pulse;
      if (wr) begin
        case (paddr)
          ADDR_W'(OFS_DIR):   dir_q   <= pwdata[NPINS-1:0];
          ADDR_W'(OFS_IEN):   ien_q   <= pwdata[NPINS-1:0];
          ADDR_W'(OFS_SENSE): sense_q <= pwdata[NPINS-1:0];
          ADDR_W'(OFS_BOTH):  both_q  <= pwdata[NPINS-1:0];
          ADDR_W'(OFS_POL):   pol_q   <= pwdata[NPINS-1:0];
          ADDR_W'(OFS_MASK):  mask_q  <= pwdata[NPINS-1:0];
          ADDR_W'(OFS_DBEN):  db_en_q <= pwdata[NPINS-1:0];
          ADDR_W'(OFS_DBDIV): div_q   <= pwdata[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  pio_sync #(.W(NPINS)) u_sync (
    .clk(pclk), .rst_n(presetn), .d(gpio_in), .q(pin_s)
  );

  pio_debounce #(.NPINS(NPINS), .DB_TICKS(DB_TICKS), .DIV_W(DIV_W)) u_db (
    .clk(pclk), .rst_n(presetn), .din(pin_s), .db_en(db_en_q), .div(div_q),
    .dout(pin_v), .tick(tick)
  );

  pio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk(pclk), .rst_n(presetn), .pin_v(pin_v), .en(ien_q), .sense(sense_q),
    .both(both_q), .pol(pol_q), .clr(icl_pulse), .mask(mask_q),
    .hit(hit), .raw(raw_q), .masked(masked), .irq(irq)
  );

  always_comb begin
    prdata = '0;
    case (paddr)
      ADDR_W'(OFS_DIR):   prdata = 32'(dir_q);
      ADDR_W'(OFS_OUT):   prdata = 32'(out_q);
      ADDR_W'(OFS_IN):    prdata = 32'(pin_v);
      ADDR_W'(OFS_IEN):   prdata = 32'(ien_q);
      ADDR_W'(OFS_SENSE): prdata = 32'(sense_q);
      ADDR_W'(OFS_BOTH):  prdata = 32'(both_q);
      ADDR_W'(OFS_POL):   prdata = 32'(pol_q);
      ADDR_W'(OFS_RAW):   prdata = 32'(raw_q);
      ADDR_W'(OFS_MASK):  prdata = 32'(mask_q);
      ADDR_W'(OFS_MSTAT): prdata = 32'(masked);
      ADDR_W'(OFS_DBEN):  prdata = 32'(db_en_q);
      ADDR_W'(OFS_DBDIV): prdata = 32'(div_q);
      default:            prdata = '0;
    endcase
  end

  assign pready   = 1'b1;
  assign gpio_out = out_q;
  assign gpio_oe  = dir_q;
endmodule

// File: rtl/pio_apb_ctrl_chk.sv
module pio_apb_ctrl_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] set_pulse,
  input logic [NPINS-1:0] clr_pulse,
  input logic [NPINS-1:0] icl_pulse,
  input logic [NPINS-1:0] hit,
  input logic [NPINS-1:0] raw,
  input logic [NPINS-1:0] ien,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] pin_v,
  input logic [NPINS-1:0] db_en,
  input logic [NPINS-1:0] gpio_out,
  input logic             tick,
  input logic             irq
);
  // R3: set strobe raises the written output bits next cycle
  p_set_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse != '0) |=> ((gpio_out & $past(set_pulse)) == $past(set_pulse)));

  // R3: clear strobe lowers the written output bits next cycle
  p_clr_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse != '0) |=> ((gpio_out & $past(clr_pulse)) == '0));

  // R8: a raw bit only rises where the pin was enabled
  p_raw_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~$past(raw) & ~$past(ien)) == '0));

  // R9: a clear with no trigger in the same cycle empties the bit
  p_icl_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((icl_pulse & ~hit) != '0) |=> (($past(icl_pulse & ~hit) & raw) == '0));

  // R10: a fully masked bank never interrupts
  p_all_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  // R11: a filtered pin changes only on the cycle after a tick
  p_db_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_v ^ $past(pin_v)) & db_en & $past(db_en)) != '0) |-> $past(tick));
endmodule

bind pio_apb_ctrl pio_apb_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(pclk), .rst_n(presetn), .set_pulse(set_pulse), .clr_pulse(clr_pulse),
  .icl_pulse(icl_pulse), .hit(hit), .raw(raw_q), .ien(ien_q), .mask(mask_q),
  .pin_v(pin_v), .db_en(db_en_q), .gpio_out(gpio_out), .tick(tick), .irq(irq)
);

// File: tb/pio_apb_ctrl_bench.sv
module pio_apb_ctrl_bench;
  localparam int CLK_P = 10;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [31:0] gin = '0;
  logic [31:0] gout, goe;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  pio_apb_ctrl u_pio_apb_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .gpio_in(gin), .gpio_out(gout), .gpio_oe(goe), .irq(irq)
  );

  always #(CLK_P/2) pclk = ~pclk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge pclk);
  endtask

  // Bench model of the trigger rules for mode m (0 rise, 1 fall, 2 both, 3 high, 4 low)
  function automatic bit exp_latch(input int m, input bit o, input bit n);
    case (m)
      0: return !o && n;
      1: return o && !n;
      2: return o != n;
      3: return o || n;     // raw held from the previous active level
      default: return !o || !n;
    endcase
  endfunction

  function automatic bit level_active(input int m, input bit n);
    if (m == 3) return n;
    if (m == 4) return !n;
    return 1'b0;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge pclk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, expo;
    idle(3);
    presetn = 1'b1;
    idle(2);

    // R1: reset state
    #1;
    chk("R1 gpio_oe", goe, 32'h0);
    chk("R1 gpio_out", gout, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    for (int a = 0; a < 16; a++) rd_chk("R1 register", 8'(a * 4), 32'h0);

    // R2: direction
    wr(8'h00, 32'hF0F0_1234);
    #1 chk("R2 gpio_oe", goe, 32'hF0F0_1234);
    rd_chk("R2 readback", 8'h00, 32'hF0F0_1234);

    // R3: set sweep, clear pattern, ignored writes
    expo = 32'h0;
    for (int p = 0; p < 32; p++) begin
      wr(8'h08, 32'h1 << p);
      expo |= 32'h1 << p;
      #1 chk("R3 set", gout, expo);
    end
    wr(8'h0C, 32'h5555_5555);
    #1 chk("R3 clear", gout, 32'hAAAA_AAAA);
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h10, 32'h0);
    rd_chk("R3 out readback", 8'h10, 32'hAAAA_AAAA);
    rd_chk("R3 set reads 0", 8'h08, 32'h0);
    rd_chk("R3 clear reads 0", 8'h0C, 32'h0);

    // R4: input readback under several patterns
    for (int k = 0; k < 4; k++) begin
      gin = 32'h1357_9BDF ^ (32'hFFFF_0000 >> (k * 4));
      rd_chk("R4 input", 8'h14, 32'h1357_9BDF ^ (32'hFFFF_0000 >> (k * 4)));
    end
    gin = 32'h0;
    idle(4);

    // R5: latency from a rising edge to irq on pin 5
    wr(8'h24, 32'h1 << 5);
    wr(8'h18, 32'h1 << 5);
    @(negedge pclk);
    gin = 32'h1 << 5;
    @(negedge pclk);
    @(negedge pclk);
    #1 chk("R5 irq not yet after 2 edges", 32'(irq), 32'h0);
    @(negedge pclk);
    #1 chk("R5 irq after 3 edges", 32'(irq), 32'h1);
    gin = 32'h0;
    idle(4);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0);
    wr(8'h24, 32'h0);

    // R5 R6 R7: mode sweep over transition sequences
    for (int m = 0; m < 5; m++) begin
      int   pin;
      bit   cur, old;
      bit   seq [5];
      logic [31:0] b;
      seq = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
      pin = (m * 7 + 1) % 32;
      b = 32'h1 << pin;
      wr(8'h1C, (m >= 3) ? b : 32'h0);
      wr(8'h20, (m == 2) ? b : 32'h0);
      wr(8'h24, (m == 0 || m == 3) ? b : ((m == 2) ? b : 32'h0)); // both ignores polarity
      wr(8'h18, b);
      idle(4);
      wr(8'h34, b);
      idle(4);
      cur = 1'b0;
      for (int k = 0; k < 5; k++) begin
        old = cur;
        cur = seq[k];
        gin = cur ? b : 32'h0;
        idle(4);
        rd(8'h28, v);
        chk($sformatf("R%0d mode%0d step%0d raw", (m < 2) ? 5 : ((m == 2) ? 6 : 7), m, k),
            v, exp_latch(m, old, cur) ? b : 32'h0);
        #1 chk("R10 irq follows raw", 32'(irq), exp_latch(m, old, cur) ? 32'h1 : 32'h0);
        wr(8'h34, b);
        idle(2);
        rd(8'h28, v);
        chk($sformatf("R7 R9 mode%0d step%0d after clear", m, k),
            v, level_active(m, cur) ? b : 32'h0);
      end
      wr(8'h18, 32'h0);
      gin = 32'h0;
      idle(4);
      wr(8'h34, 32'hFFFF_FFFF);
    end
    wr(8'h1C, 32'h0);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h0);

    // R8: disabled pin does not latch, enabled pin does
    wr(8'h24, 32'h1 << 9);
    gin = 32'h1 << 9;
    idle(4);
    rd_chk("R8 disabled no latch", 8'h28, 32'h0);
    gin = 32'h0;
    wr(8'h18, 32'h1 << 9);
    idle(2);
    gin = 32'h1 << 9;
    idle(4);
    rd_chk("R8 enabled latches", 8'h28, 32'h1 << 9);

    // R10: masking
    wr(8'h2C, 32'h1 << 9);
    rd_chk("R10 masked status hidden", 8'h30, 32'h0);
    #1 chk("R10 irq masked", 32'(irq), 32'h0);
    rd_chk("R10 raw kept", 8'h28, 32'h1 << 9);
    wr(8'h2C, 32'h0);
    rd_chk("R10 masked status", 8'h30, 32'h1 << 9);
    #1 chk("R10 irq unmasked", 32'(irq), 32'h1);
    wr(8'h34, 32'h1 << 9);
    #1 chk("R9 clear drops irq", 32'(irq), 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h24, 32'h0);
    gin = 32'h0;

    // R11: debounce on pin 3, tick every 3 clocks; pin 4 unfiltered
    wr(8'h3C, 32'h2);
    wr(8'h38, 32'h1 << 3);
    rd_chk("R11 divider readback", 8'h3C, 32'h2);
    idle(2);
    @(negedge pclk);
    gin = (32'h1 << 3) | (32'h1 << 4);
    idle(5);
    #1;
    rd(8'h14, v);
    chk("R11 filtered pin not yet", v & (32'h1 << 3), 32'h0);
    chk("R4 unfiltered pin fast", v & (32'h1 << 4), 32'h1 << 4);
    idle(25);
    rd(8'h14, v);
    chk("R11 filtered pin accepted", v & (32'h1 << 3), 32'h1 << 3);
    gin = 32'h0;
    idle(40);
    rd_chk("R11 filtered falls", 8'h14, 32'h0);
    @(negedge pclk);
    gin = 32'h1 << 3;
    idle(4);
    gin = 32'h0;
    idle(40);
    rd_chk("R11 glitch rejected", 8'h14, 32'h0);

    // R12: reserved and unmapped reads, ready
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R12 control reads 0", 8'h04, 32'h0);
    rd_chk("R12 unmapped reads 0", 8'h40, 32'h0);
    rd_chk("R12 unmapped high reads 0", 8'hFC, 32'h0);
    chk("R12 pready", 32'(pready), 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule